// File: doc/BRIEF.md
# Chip-Select Configuration Register and Address Decoder

This block owns the configuration of one external-memory chip select. Software programs a 32-bit configuration word and a 32-bit timing word through a small Wishbone-style register port. The upstream interconnect decodes the register space and presents only the low byte of the offset. The configuration word carries an enable bit, an 8-bit select value, a write-protect bit and the access-mode fields. These are the memory type, the per-device bus width, the device size, keep-row-open, bank-address-select and parity enable. Each field is driven out as a plain control pin for the downstream memory sequencer. The timing word is stored as written and handed to the sequencer unchanged.

On the memory side the block decodes every access attempt. An attempt belongs to this chip select when the enable bit is set and address bits [28:21] equal the select value. An access that hits is forwarded to the sequencer on a valid/ready channel. The only exception is a write while write protection is set. That write is consumed at once, never reaches the sequencer, and is answered with a one-cycle error pulse.

Back-pressure rules: `seq_valid` mirrors an accepted request combinationally and `acc_ready` follows `seq_ready` for forwarded traffic. A protected write is always ready. A missed access is never ready, so another chip select may take it. A requester must hold `acc_valid`, `acc_we` and `acc_addr` stable until `acc_ready` is seen high at a clock edge.

Top module: `cs_decoder`

## Requirements
- R1: After reset both words read as zero and the enable bit is 0, so `cs_hit` is 0 for every address, including one whose bits [28:21] equal the reset select value 0.
- R2: Offset 0x28 holds the configuration word: bit 0 enable, [3:1] memory type, [5:4] bus width, [7:6] device size, [8] write protect, [9] bank-address-select, [10] keep-row-open, [11] parity enable, [23:16] select value. Bits [31:24] and [15:12] read back as zero whatever was written.
- R3: Offset 0x2C holds the timing word; all 32 bits read back exactly as written and appear on `timing_word`.
- R4: An access to any other offset is acknowledged. A read there returns zero, and a write there changes neither stored word.
- R5: `wb_ack` rises on the clock edge after `wb_cyc` and `wb_stb` are first seen together and stays high for exactly one cycle. Read data is valid while `wb_ack` is high, and a write takes effect at that same edge.
- R6: `cs_hit` is 1 in the same cycle exactly when the enable bit is 1 and `acc_addr[28:21]` equals the select value; address bits outside [28:21] do not matter.
- R7: The field pins follow the configuration word: `mem_type`=[3:1], `bus_width`=[5:4], `dev_size`=[7:6], `bank_sel`=[9], `keep_row_open`=[10], `parity_en`=[11], and `mem_is_sdram` is 1 exactly when the memory type is 000.
- R8: A valid access that hits, and is a read or an unprotected write, drives `seq_valid` high in the same cycle with `acc_ready` equal to `seq_ready`.
- R9: A valid write that hits while write protect is 1 keeps `seq_valid` low and drives `acc_ready` high. `acc_err` is then high for one cycle after the accepting edge. Reads under write protect are forwarded as in R8.
- R10: A valid access that misses keeps `seq_valid`, `acc_ready` and `acc_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc | input | 1 | Register bus cycle |
| wb_stb | input | 1 | Register bus strobe |
| wb_we | input | 1 | Register write when 1 |
| wb_adr | input | 8 | Register byte offset |
| wb_dat_i | input | 32 | Register write data |
| wb_dat_o | output | 32 | Register read data |
| wb_ack | output | 1 | Register access acknowledge |
| acc_valid | input | 1 | Memory access attempt valid |
| acc_we | input | 1 | Memory access is a write |
| acc_addr | input | 32 | Memory access byte address |
| acc_ready | output | 1 | Access accepted at this edge |
| acc_err | output | 1 | Protected write rejected (one cycle) |
| seq_valid | output | 1 | Forwarded request to sequencer |
| seq_ready | input | 1 | Sequencer can accept |
| cs_hit | output | 1 | Address decodes to this chip select |
| mem_type | output | 3 | Memory type code |
| mem_is_sdram | output | 1 | Memory type is SDRAM |
| bus_width | output | 2 | Per-device bus width code |
| dev_size | output | 2 | Device size code |
| keep_row_open | output | 1 | Keep row open after access |
| bank_sel | output | 1 | Bank address selection mode |
| parity_en | output | 1 | Parity enable |
| timing_word | output | 32 | Stored timing word |

## Verification
The hardest case to reach is the rejected write. It requires enable, a matching select value and write protect all programmed at once, followed by a write whose bits [28:21] match while other high bits are deliberately set. The bench programs the word through the register port and then raises write protect with a second register write. In between it checks that the same write was still forwarded. It then drives a single-cycle write attempt and watches for the error pulse on the following cycle. A read of the same address is driven afterwards, to show that protection applies only to writes.

// File: rtl/cs_pkg.sv
package cs_pkg;
  // live fields of the configuration word; reserved bits are not stored
  typedef struct packed {
    logic [7:0] sel;
    logic       par_en;
    logic       keep_row;
    logic       bank_sel;
    logic       wprot;
    logic [1:0] dev_size;
    logic [1:0] bus_w;
    logic [2:0] mtype;
    logic       en;
  } cs_cfg_t;

  parameter logic [2:0] MTYPE_SDRAM = 3'b000;

  function automatic logic [31:0] cfg_to_word(cs_cfg_t c);
    return {8'h00, c.sel, 4'h0, c.par_en, c.keep_row, c.bank_sel, c.wprot,
            c.dev_size, c.bus_w, c.mtype, c.en};
  endfunction

  function automatic cs_cfg_t word_to_cfg(logic [31:0] w);
    cs_cfg_t c;
    c.sel      = w[23:16];
    c.par_en   = w[11];
    c.keep_row = w[10];
    c.bank_sel = w[9];
    c.wprot    = w[8];
    c.dev_size = w[7:6];
    c.bus_w    = w[5:4];
    c.mtype    = w[3:1];
    c.en       = w[0];
    return c;
  endfunction
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
  import cs_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int DW = 32,
  parameter logic [OFS_W-1:0] CFG_OFS = 8'h28,
  parameter logic [OFS_W-1:0] TIM_OFS = 8'h2C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [OFS_W-1:0] adr,
  input  logic [DW-1:0]    dat_i,
  output logic [DW-1:0]    dat_o,
  output logic             ack,
  output cs_cfg_t          cfg_o,
  output logic [DW-1:0]    tim_o
);
  cs_cfg_t       cfg_q;
  logic [DW-1:0] tim_q;
  logic [DW-1:0] dat_q;
  logic          ack_q;
  logic          req;
  logic          hit_cfg, hit_tim;
  logic [DW-1:0] rdata;

  assign req     = cyc && stb && !ack_q;
  assign hit_cfg = (adr == CFG_OFS);
  assign hit_tim = (adr == TIM_OFS);

  always_comb begin
    rdata = '0;
    if (hit_cfg)      rdata = cfg_to_word(cfg_q);
    else if (hit_tim) rdata = tim_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      tim_q <= '0;
      dat_q <= '0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= req;
      if (req) begin
        dat_q <= we ? '0 : rdata;
        if (we && hit_cfg) cfg_q <= word_to_cfg(dat_i);
        if (we && hit_tim) tim_q <= dat_i;
      end
    end
  end

  assign dat_o = dat_q;
  assign ack   = ack_q;
  assign cfg_o = cfg_q;
  assign tim_o = tim_q;

  // R5: acknowledge is a single-cycle pulse
  a_r5_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  // R5: acknowledge only follows a request
  a_r5_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(cyc && stb));

  // R4: unmapped write leaves both words unchanged
  a_r4_unmapped_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !hit_cfg && !hit_tim) |=> ($stable(cfg_q) && $stable(tim_q)));

  // R4: unmapped read returns zero
  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && !hit_cfg && !hit_tim) |=> (dat_o == '0));
endmodule

// File: rtl/cs_match.sv
module cs_match #(
  parameter int AW = 32,
  parameter int SEL_LO = 21,
  parameter int SEL_W = 8
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [AW-1:0]    addr,
  output logic             hit
);
  localparam int SEL_HI = SEL_LO + SEL_W - 1;

  logic [SEL_W-1:0] slice;
  assign slice = addr[SEL_HI:SEL_LO];
  assign hit   = en && (slice == sel);

  // R6: a hit always has enable set
  always_comb begin
    a_r6_hit_needs_en: assert (!hit || en);
  end
endmodule

// File: rtl/cs_gate.sv
module cs_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic wprot,
  input  logic acc_valid,
  input  logic acc_we,
  input  logic seq_ready,
  output logic seq_valid,
  output logic acc_ready,
  output logic acc_err
);
  logic blocked;
  logic fwd;
  logic err_q;

  assign blocked   = acc_valid && hit && acc_we && wprot;
  assign fwd       = acc_valid && hit && !(acc_we && wprot);
  assign seq_valid = fwd;
  assign acc_ready = blocked || (fwd && seq_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= blocked;
  end
  assign acc_err = err_q;

  // R9: a protected write never reaches the sequencer
  a_r9_no_protected_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_we && wprot) |-> !seq_valid);

  // R9: the error pulse follows an accepted write attempt
  a_r9_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(acc_valid && acc_we && acc_ready));

  // R10: a miss is neither forwarded nor accepted
  a_r10_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!seq_valid && !acc_ready));
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OFS_W = 8,
  parameter int SEL_LO = 21,
  parameter int SEL_W = 8,
  parameter logic [OFS_W-1:0] CFG_OFS = 8'h28,
  parameter logic [OFS_W-1:0] TIM_OFS = 8'h2C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_cyc,
  input  logic             wb_stb,
  input  logic             wb_we,
  input  logic [OFS_W-1:0] wb_adr,
  input  logic [DW-1:0]    wb_dat_i,
  output logic [DW-1:0]    wb_dat_o,
  output logic             wb_ack,
  input  logic             acc_valid,
  input  logic             acc_we,
  input  logic [AW-1:0]    acc_addr,
  output logic             acc_ready,
  output logic             acc_err,
  output logic             seq_valid,
  input  logic             seq_ready,
  output logic             cs_hit,
  output logic [2:0]       mem_type,
  output logic             mem_is_sdram,
  output logic [1:0]       bus_width,
  output logic [1:0]       dev_size,
  output logic             keep_row_open,
  output logic             bank_sel,
  output logic             parity_en,
  output logic [DW-1:0]    timing_word
);
  cs_cfg_t cfg;
  logic    hit;

  cs_regfile #(.OFS_W(OFS_W), .DW(DW), .CFG_OFS(CFG_OFS), .TIM_OFS(TIM_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n), .cyc(wb_cyc), .stb(wb_stb), .we(wb_we),
    .adr(wb_adr), .dat_i(wb_dat_i), .dat_o(wb_dat_o), .ack(wb_ack),
    .cfg_o(cfg), .tim_o(timing_word)
  );

  cs_match #(.AW(AW), .SEL_LO(SEL_LO), .SEL_W(SEL_W)) u_match (
    .en(cfg.en), .sel(cfg.sel), .addr(acc_addr), .hit(hit)
  );

  cs_gate u_gate (
    .clk(clk), .rst_n(rst_n), .hit(hit), .wprot(cfg.wprot),
    .acc_valid(acc_valid), .acc_we(acc_we), .seq_ready(seq_ready),
    .seq_valid(seq_valid), .acc_ready(acc_ready), .acc_err(acc_err)
  );

  assign cs_hit        = hit;
  assign mem_type      = cfg.mtype;
  assign mem_is_sdram  = (cfg.mtype == MTYPE_SDRAM);
  assign bus_width     = cfg.bus_w;
  assign dev_size      = cfg.dev_size;
  assign keep_row_open = cfg.keep_row;
  assign bank_sel      = cfg.bank_sel;
  assign parity_en     = cfg.par_en;

  // R1: nothing decodes in the first cycle after reset
  a_r1_no_hit_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !cs_hit);
endmodule

// File: tb/sim_cs_decoder.sv
module sim_cs_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [7:0]  wb_adr = '0;
  logic [31:0] wb_dat_i = '0;
  logic [31:0] wb_dat_o;
  logic        wb_ack;
  logic        acc_valid = 0, acc_we = 0, seq_ready = 0;
  logic [31:0] acc_addr = '0;
  logic        acc_ready, acc_err, seq_valid, cs_hit;
  logic [2:0]  mem_type;
  logic        mem_is_sdram, keep_row_open, bank_sel, parity_en;
  logic [1:0]  bus_width, dev_size;
  logic [31:0] timing_word;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cs_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack(wb_ack),
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_ready(acc_ready), .acc_err(acc_err), .seq_valid(seq_valid),
    .seq_ready(seq_ready), .cs_hit(cs_hit), .mem_type(mem_type),
    .mem_is_sdram(mem_is_sdram), .bus_width(bus_width), .dev_size(dev_size),
    .keep_row_open(keep_row_open), .bank_sel(bank_sel), .parity_en(parity_en),
    .timing_word(timing_word)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // one register access; returns read data sampled while ack is high
  task automatic reg_xfer(input logic we, input logic [7:0] ofs,
                          input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = ofs; wb_dat_i = wd;
    #1 chk("R5 ack low in request cycle", {31'b0, wb_ack}, 32'd0);
    @(negedge clk);
    chk("R5 ack one cycle after request", {31'b0, wb_ack}, 32'd1);
    rd = wb_dat_o;
    wb_cyc = 0; wb_stb = 0; wb_we = 0;
    @(negedge clk);
    chk("R5 ack drops after one cycle", {31'b0, wb_ack}, 32'd0);
  endtask

  task automatic reg_wr(input logic [7:0] ofs, input logic [31:0] wd);
    logic [31:0] dummy;
    reg_xfer(1'b1, ofs, wd, dummy);
  endtask

  task automatic reg_rd(input logic [7:0] ofs, output logic [31:0] rd);
    reg_xfer(1'b0, ofs, 32'h0, rd);
  endtask

  task automatic t_reset;
    logic [31:0] rd;
    acc_addr = 32'h0;
    #1 chk("R1 no hit after reset", {31'b0, cs_hit}, 32'd0);
    reg_rd(8'h28, rd); chk("R1 config zero", rd, 32'h0);
    reg_rd(8'h2C, rd); chk("R1 timing zero", rd, 32'h0);
  endtask

  task automatic t_config;
    logic [31:0] rd;
    reg_wr(8'h28, 32'hFFFF_FFFF);
    reg_rd(8'h28, rd); chk("R2 reserved bits read zero", rd, 32'h00FF_0FFF);
    reg_wr(8'h28, 32'h0003_0491);
    reg_rd(8'h28, rd); chk("R2 config readback", rd, 32'h0003_0491);
    chk("R7 mem_type", {29'b0, mem_type}, 32'd0);
    chk("R7 sdram flag", {31'b0, mem_is_sdram}, 32'd1);
    chk("R7 bus width", {30'b0, bus_width}, 32'd1);
    chk("R7 dev size", {30'b0, dev_size}, 32'd2);
    chk("R7 keep row", {31'b0, keep_row_open}, 32'd1);
    chk("R7 bank sel", {31'b0, bank_sel}, 32'd0);
    chk("R7 parity", {31'b0, parity_en}, 32'd0);
  endtask

  task automatic t_fields_alt;
    reg_wr(8'h28, 32'h0003_0A25);
    chk("R7 mem_type 010", {29'b0, mem_type}, 32'd2);
    chk("R7 not sdram", {31'b0, mem_is_sdram}, 32'd0);
    chk("R7 bank sel set", {31'b0, bank_sel}, 32'd1);
    chk("R7 parity set", {31'b0, parity_en}, 32'd1);
    chk("R7 keep row clear", {31'b0, keep_row_open}, 32'd0);
    chk("R7 bus width 10", {30'b0, bus_width}, 32'd2);
    chk("R7 dev size 00", {30'b0, dev_size}, 32'd0);
    reg_wr(8'h28, 32'h0003_0491);
  endtask

  task automatic t_timing;
    logic [31:0] rd;
    reg_wr(8'h2C, 32'hA5C3_0F69);
    reg_rd(8'h2C, rd); chk("R3 timing readback", rd, 32'hA5C3_0F69);
    chk("R3 timing pins", timing_word, 32'hA5C3_0F69);
  endtask

  task automatic t_unmapped;
    logic [31:0] rd;
    reg_wr(8'h30, 32'hFFFF_FFFF);
    reg_rd(8'h30, rd); chk("R4 unmapped reads zero", rd, 32'h0);
    reg_rd(8'h28, rd); chk("R4 config untouched", rd, 32'h0003_0491);
    reg_rd(8'h2C, rd); chk("R4 timing untouched", rd, 32'hA5C3_0F69);
  endtask

  task automatic t_match;
    @(negedge clk);
    acc_addr = 32'h0060_0000;
    #1 chk("R6 hit on matching slice", {31'b0, cs_hit}, 32'd1);
    acc_addr = 32'hE07F_FFFC;
    #1 chk("R6 outer bits ignored", {31'b0, cs_hit}, 32'd1);
    acc_addr = 32'h0080_0000;
    #1 chk("R6 miss on other slice", {31'b0, cs_hit}, 32'd0);
    acc_addr = 32'h0040_0000;
    #1 chk("R6 miss on lower slice", {31'b0, cs_hit}, 32'd0);
  endtask

  task automatic t_forward;
    @(negedge clk);
    acc_addr = 32'h0060_0010; acc_we = 1; acc_valid = 1; seq_ready = 0;
    #1 chk("R8 write forwarded", {31'b0, seq_valid}, 32'd1);
    chk("R8 stalled by sequencer", {31'b0, acc_ready}, 32'd0);
    seq_ready = 1;
    #1 chk("R8 ready follows sequencer", {31'b0, acc_ready}, 32'd1);
    @(negedge clk);
    acc_valid = 0; acc_we = 0; seq_ready = 0;
    chk("R8 no error on forwarded write", {31'b0, acc_err}, 32'd0);
  endtask

  task automatic t_protect;
    reg_wr(8'h28, 32'h0003_0591);
    @(negedge clk);
    acc_addr = 32'hE060_0020; acc_we = 1; acc_valid = 1; seq_ready = 0;
    #1 chk("R9 protected write not forwarded", {31'b0, seq_valid}, 32'd0);
    chk("R9 protected write accepted", {31'b0, acc_ready}, 32'd1);
    chk("R9 no error before edge", {31'b0, acc_err}, 32'd0);
    @(negedge clk);
    acc_valid = 0; acc_we = 0;
    chk("R9 error pulse", {31'b0, acc_err}, 32'd1);
    @(negedge clk);
    chk("R9 error one cycle", {31'b0, acc_err}, 32'd0);
    acc_valid = 1; seq_ready = 1;
    #1 chk("R9 read forwarded under protect", {31'b0, seq_valid}, 32'd1);
    @(negedge clk);
    acc_valid = 0; seq_ready = 0;
    chk("R9 no error on read", {31'b0, acc_err}, 32'd0);
  endtask

  task automatic t_miss;
    @(negedge clk);
    acc_addr = 32'h1FE0_0000; acc_we = 1; acc_valid = 1; seq_ready = 1;
    #1 chk("R10 miss not forwarded", {31'b0, seq_valid}, 32'd0);
    chk("R10 miss not ready", {31'b0, acc_ready}, 32'd0);
    @(negedge clk);
    acc_valid = 0; acc_we = 0; seq_ready = 0;
    chk("R10 miss no error", {31'b0, acc_err}, 32'd0);
    reg_wr(8'h28, 32'h0003_0490);
    acc_addr = 32'h0060_0000;
    #1 chk("R6 disabled select never hits", {31'b0, cs_hit}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_config;
    t_fields_alt;
    t_timing;
    t_unmapped;
    t_match;
    t_forward;
    t_protect;
    t_miss;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule